// File: doc/BRIEF.md
# Crypto Start and Busy Sequencer

This block decides, cycle by cycle, when a block-cipher operation may begin. It watches the fill level of an input word FIFO, the free space of an output word FIFO, an enable bit, a direction bit, an algorithm select, a key-length select and a chaining-mode select. When every start condition holds, it takes one whole block of words from the input FIFO in a single cycle. It then holds a busy flag for a fixed number of cycles, and that number depends on the algorithm and the key length. On the last busy cycle it pushes the whole result block into the output FIFO and updates the chaining value.

The cipher arithmetic is not part of this block. A cheap invertible stand-in transform takes its place, so the chaining paths and the scoreboard have real data to carry.

There is no per-word valid/ready pair on either FIFO edge, because each transfer moves a whole block at once. The input side offers a level and the first four words. The block answers with a one-cycle pop strobe and a word count. Back-pressure on the output side is expressed only by the free-space count. No operation starts unless the whole result already fits, so the push is never refused and never overflows.

Top module: `crypseq_top`

## Requirements
- R1: A start happens only in a cycle where `enable`=1, `busy`=0, `algo` is legal and both `in_level` and `out_free` are at least N. N is 2 for `algo`=00 (single DES) and for `algo`=01 (triple DES). N is 4 for `algo`=10 (AES). `algo`=11 never starts.
- R2: In the start cycle, `in_pop` is high for exactly one cycle and `in_pop_cnt`=N. The block is taken from `in_words`, with the oldest word in bits [127:96] and the following words in the lower slots in order.
- R3: `busy` rises in the cycle after the start and stays high for exactly L cycles. L is 16 for single DES and 48 for triple DES. For AES, L is 14, 16 or 18 when `keylen` is 00, 01 or 10, and `keylen`=11 gives 18.
- R4: In the last busy cycle, `out_push` is high for one cycle with `out_cnt`=N. The result is placed in `out_words` with the same word order as R2, and the unused slots read zero. `busy` is low in the next cycle.
- R5: `decrypt`=0 encrypts and `decrypt`=1 decrypts. Take x as the block of BW bits (64 or 128) built from the words, and K as the top BW bits of `STANDIN_KEY` (default 0F1E2D3C4B5A69788796A5B4C3D2E1F0 in hex). The stand-in forward transform is E(x) = rotate-left(x, 8) XOR K. The inverse is D(y) = rotate-right(y XOR K, 8).
- R6: `chain_mode` selects the chaining mode: 00 is ECB, 01 is CBC, 10 is counter, and 11 behaves as ECB. The chaining value c is `iv_o` for AES and `iv_o[127:64]` for DES and triple DES.
  - ECB gives E or D of x and leaves c unchanged.
  - CBC encrypt gives E(x XOR c) and then sets c to the result.
  - CBC decrypt gives D(x) XOR c and then sets c to x.
  - Counter mode gives x XOR E(c) in both directions and then sets c to c+1 modulo 2^BW.
  - For DES and triple DES, `iv_o[63:0]` is never changed by these updates.
- R7: The configuration inputs are sampled in the start cycle. Changing them during busy has no effect on the running block. Clearing `enable` during busy does not abort the block, and no new block starts until `enable` returns to 1.
- R8: `iv_wr`=1 loads `iv_wdata` into `iv_o` in a cycle with `busy`=0. A write made while busy is ignored.
- R9: A new start may happen in the cycle right after `busy` falls.
- R10: After reset, `busy`, `in_pop` and `out_push` are 0 and `iv_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Allows automatic starts |
| decrypt | input | 1 | 0 encrypt, 1 decrypt |
| algo | input | 2 | 00 DES, 01 triple DES, 10 AES, 11 reserved |
| keylen | input | 2 | AES key length: 00 128, 01 192, 10/11 256 |
| chain_mode | input | 2 | 00 ECB, 01 CBC, 10 counter, 11 as ECB |
| in_level | input | LW (5) | Words held by the input FIFO |
| in_words | input | 4*W (128) | Oldest four input FIFO words, oldest in the top slot |
| in_pop | output | 1 | Removes `in_pop_cnt` words from the input FIFO |
| in_pop_cnt | output | 3 | Words removed (2 or 4) |
| out_free | input | LW (5) | Free locations in the output FIFO |
| out_push | output | 1 | Writes `out_cnt` words into the output FIFO |
| out_cnt | output | 3 | Words written (2 or 4) |
| out_words | output | 4*W (128) | Result words, first word in the top slot |
| iv_wr | input | 1 | Loads the chaining value while idle |
| iv_wdata | input | 4*W (128) | Chaining value to load |
| iv_o | output | 4*W (128) | Current chaining value |
| busy | output | 1 | High for the whole processing interval |

## Verification
The start gate is tried with each of its conditions withheld in turn: enable low, one word short for a DES block, one free location short for an AES block, and a reserved algorithm. Only the missing condition is absent each time, so a wrong threshold or a missing term shows up as a premature pop. Busy length is measured for every algorithm and key length, which separates each latency entry from its neighbours. ECB, CBC and counter blocks are run in both directions and at both block widths, and runs of chained blocks are used so that an update of the wrong chaining half or to the wrong value corrupts the next expected result. Configuration changes and enable clearing during busy, writes to the chaining value while busy, and two queued blocks are used to tell apart the sampling point of the configuration, the gating of writes and the one-cycle restart gap.

// File: rtl/crypseq_pkg.sv
`timescale 1ns/1ps
package crypseq_pkg;

  typedef enum logic [1:0] {
    ALG_DES  = 2'b00,
    ALG_TDES = 2'b01,
    ALG_AES  = 2'b10,
    ALG_RSVD = 2'b11
  } alg_e;

  typedef enum logic [1:0] {
    CH_ECB  = 2'b00,
    CH_CBC  = 2'b01,
    CH_CTR  = 2'b10,
    CH_RSVD = 2'b11
  } chain_e;

  typedef struct packed {
    alg_e   alg;
    logic   decrypt;
    chain_e chain;
  } op_cfg_t;

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/crypseq_profile.sv
`timescale 1ns/1ps
module crypseq_profile
  import crypseq_pkg::*;
#(
  parameter int CNTW       = 6,
  parameter int LAT_DES    = 16,
  parameter int LAT_TDES   = 48,
  parameter int LAT_AES128 = 14,
  parameter int LAT_AES192 = 16,
  parameter int LAT_AES256 = 18
) (
  input  alg_e             alg,
  input  logic [1:0]       keylen,
  output logic             legal,
  output logic             wide,
  output logic [CNTW-1:0]  lat
);

  always_comb begin
    legal = 1'b1;
    wide  = 1'b0;
    lat   = CNTW'(LAT_DES);
    unique case (alg)
      ALG_DES:  lat = CNTW'(LAT_DES);
      ALG_TDES: lat = CNTW'(LAT_TDES);
      ALG_AES: begin
        wide = 1'b1;
        unique case (keylen)
          2'b00:   lat = CNTW'(LAT_AES128);
          2'b01:   lat = CNTW'(LAT_AES192);
          default: lat = CNTW'(LAT_AES256);
        endcase
      end
      default: begin
        legal = 1'b0;
        wide  = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/crypseq_standin.sv
`timescale 1ns/1ps
module crypseq_standin #(
  parameter int            BW  = 64,
  parameter logic [BW-1:0] KEY = '0,
  parameter int            ROT = 8
) (
  input  logic [BW-1:0] din,
  input  logic          decrypt,
  output logic [BW-1:0] dout
);

  logic [BW-1:0] keyed;
  logic [BW-1:0] fwd;
  logic [BW-1:0] inv;

  assign keyed = din ^ KEY;
  assign fwd   = {din[BW-ROT-1:0], din[BW-1:BW-ROT]} ^ KEY;
  assign inv   = {keyed[ROT-1:0], keyed[BW-1:ROT]};
  assign dout  = decrypt ? inv : fwd;

endmodule

// File: rtl/crypseq_chain.sv
`timescale 1ns/1ps
module crypseq_chain
  import crypseq_pkg::*;
#(
  parameter int            BW  = 64,
  parameter logic [BW-1:0] KEY = '0,
  parameter int            ROT = 8
) (
  input  logic [BW-1:0] blk,
  input  logic [BW-1:0] iv,
  input  logic          decrypt,
  input  chain_e        chain,
  output logic [BW-1:0] res,
  output logic [BW-1:0] iv_next
);

  logic [BW-1:0] core_in;
  logic [BW-1:0] core_out;
  logic          core_dec;

  crypseq_standin #(.BW(BW), .KEY(KEY), .ROT(ROT)) u_core (
    .din    (core_in),
    .decrypt(core_dec),
    .dout   (core_out)
  );

  always_comb begin
    core_in  = blk;
    core_dec = decrypt;
    res      = core_out;
    iv_next  = iv;
    unique case (chain)
      CH_CBC: begin
        if (decrypt) begin
          res     = core_out ^ iv;
          iv_next = blk;
        end else begin
          core_in = blk ^ iv;
          iv_next = core_out;
        end
      end
      CH_CTR: begin
        core_in  = iv;
        core_dec = 1'b0;
        res      = blk ^ core_out;
        iv_next  = iv + 1'b1;
      end
      default: begin
        res     = core_out;
        iv_next = iv;
      end
    endcase
  end

endmodule

// File: rtl/crypseq_top.sv
`timescale 1ns/1ps
module crypseq_top
  import crypseq_pkg::*;
#(
  parameter int               W           = 32,
  parameter int               LW          = 5,
  parameter int               ROT         = 8,
  parameter int               LAT_DES     = 16,
  parameter int               LAT_TDES    = 48,
  parameter int               LAT_AES128  = 14,
  parameter int               LAT_AES192  = 16,
  parameter int               LAT_AES256  = 18,
  parameter logic [4*W-1:0]   STANDIN_KEY = 128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             decrypt,
  input  logic [1:0]       algo,
  input  logic [1:0]       keylen,
  input  logic [1:0]       chain_mode,
  input  logic [LW-1:0]    in_level,
  input  logic [4*W-1:0]   in_words,
  output logic             in_pop,
  output logic [2:0]       in_pop_cnt,
  input  logic [LW-1:0]    out_free,
  output logic             out_push,
  output logic [2:0]       out_cnt,
  output logic [4*W-1:0]   out_words,
  input  logic             iv_wr,
  input  logic [4*W-1:0]   iv_wdata,
  output logic [4*W-1:0]   iv_o,
  output logic             busy
);

  localparam int DW      = 4 * W;
  localparam int LAT_MAX = imax(imax(imax(LAT_DES, LAT_TDES), imax(LAT_AES128, LAT_AES192)), LAT_AES256);
  localparam int CNTW    = $clog2(LAT_MAX + 1);

  // Operation profile of the currently presented configuration
  logic            legal;
  logic            wide;
  logic [CNTW-1:0] lat;

  crypseq_profile #(
    .CNTW(CNTW), .LAT_DES(LAT_DES), .LAT_TDES(LAT_TDES),
    .LAT_AES128(LAT_AES128), .LAT_AES192(LAT_AES192), .LAT_AES256(LAT_AES256)
  ) u_profile (
    .alg   (alg_e'(algo)),
    .keylen(keylen),
    .legal (legal),
    .wide  (wide),
    .lat   (lat)
  );

  // Sequencer state
  op_cfg_t         cfg_q;
  logic [DW-1:0]   blk_q;
  logic [DW-1:0]   iv_q;
  logic [CNTW-1:0] cnt_q;
  logic            busy_w;
  logic            last_w;
  logic            start;
  logic [LW-1:0]   need;
  logic            wide_q;

  assign busy_w = (cnt_q != '0);
  assign last_w = (cnt_q == CNTW'(1));
  assign need   = wide ? LW'(4) : LW'(2);
  assign start  = enable && legal && !busy_w && (in_level >= need) && (out_free >= need);
  assign wide_q = (cfg_q.alg == ALG_AES);

  // Datapath at both block widths; the captured algorithm picks one
  logic [DW-1:0] res_v [2];
  logic [DW-1:0] ivn_v [2];

  for (genvar g = 0; g < 2; g++) begin : g_width
    localparam int BW = 2 * W * (g + 1);
    logic [BW-1:0] r_w;
    logic [BW-1:0] n_w;

    crypseq_chain #(
      .BW (BW),
      .KEY(STANDIN_KEY[DW-1 -: BW]),
      .ROT(ROT)
    ) u_chain (
      .blk    (blk_q[DW-1 -: BW]),
      .iv     (iv_q[DW-1 -: BW]),
      .decrypt(cfg_q.decrypt),
      .chain  (cfg_q.chain),
      .res    (r_w),
      .iv_next(n_w)
    );

    if (BW == DW) begin : g_full
      assign res_v[g] = r_w;
      assign ivn_v[g] = n_w;
    end else begin : g_half
      assign res_v[g] = {r_w, {(DW-BW){1'b0}}};
      assign ivn_v[g] = {n_w, iv_q[DW-BW-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      blk_q <= '0;
      iv_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (start) begin
        cfg_q <= '{alg: alg_e'(algo), decrypt: decrypt, chain: chain_e'(chain_mode)};
        blk_q <= in_words;
        cnt_q <= lat;
      end else if (busy_w) begin
        cnt_q <= cnt_q - 1'b1;
      end
      if (busy_w && last_w) begin
        iv_q <= wide_q ? ivn_v[1] : ivn_v[0];
      end else if (!busy_w && iv_wr) begin
        iv_q <= iv_wdata;
      end
    end
  end

  assign in_pop     = start;
  assign in_pop_cnt = wide ? 3'd4 : 3'd2;
  assign out_push   = busy_w && last_w;
  assign out_cnt    = wide_q ? 3'd4 : 3'd2;
  assign out_words  = out_push ? (wide_q ? res_v[1] : res_v[0]) : '0;
  assign iv_o       = iv_q;
  assign busy       = busy_w;

  // Assertions guarding the start gate, busy window and chaining register
  p_pop_fits_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_pop |-> (in_level >= LW'(in_pop_cnt)) && (out_free >= LW'(in_pop_cnt)));

  p_no_start_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !in_pop);

  p_pop_size_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_pop |-> (in_pop_cnt == 3'd2 || in_pop_cnt == 3'd4));

  p_busy_follows_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_pop |=> busy);

  p_no_pop_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_pop);

  p_push_in_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_push |-> busy);

  p_push_ends_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_push |=> !busy);

  p_iv_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !out_push) |=> $stable(iv_o));

endmodule

// File: tb/crypseq_top_test.sv
`timescale 1ns/1ps
module crypseq_top_test;

  localparam logic [127:0] KEY = 128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         enable, decrypt;
  logic [1:0]   algo, keylen, chain_mode;
  logic [4:0]   in_level;
  logic [127:0] in_words;
  logic         in_pop;
  logic [2:0]   in_pop_cnt;
  logic [4:0]   out_free;
  logic         out_push;
  logic [2:0]   out_cnt;
  logic [127:0] out_words;
  logic         iv_wr;
  logic [127:0] iv_wdata;
  logic [127:0] iv_o;
  logic         busy;

  always #10 clk = ~clk;

  crypseq_top uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .decrypt(decrypt),
    .algo(algo), .keylen(keylen), .chain_mode(chain_mode),
    .in_level(in_level), .in_words(in_words), .in_pop(in_pop), .in_pop_cnt(in_pop_cnt),
    .out_free(out_free), .out_push(out_push), .out_cnt(out_cnt), .out_words(out_words),
    .iv_wr(iv_wr), .iv_wdata(iv_wdata), .iv_o(iv_o), .busy(busy)
  );

  int checks = 0;
  int failures = 0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Input FIFO model
  logic [31:0] mem [0:63];
  int rd_p = 0;
  int wr_p = 0;
  int cyc  = 0;

  always_comb begin
    int d;
    d = wr_p - rd_p;
    in_level = (d > 31) ? 5'd31 : 5'(d);
    in_words = {mem[rd_p % 64], mem[(rd_p + 1) % 64], mem[(rd_p + 2) % 64], mem[(rd_p + 3) % 64]};
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (in_pop) rd_p <= rd_p + int'(in_pop_cnt);
  end

  // Scoreboard
  logic [127:0] q_res [$];
  int           q_lat [$];
  int           q_n   [$];
  int           n_expect = 2;
  int           run = 0;
  int           last_push = -10;
  bit           post_push = 0;
  bit           b2b_armed = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (post_push) begin
        chk(busy == 1'b0, "R4 busy low after push", 128'(busy), 128'(0));
        post_push = 0;
      end
      if (busy) run++;
      if (in_pop) begin
        chk(int'(in_pop_cnt) == n_expect, "R2 pop count", 128'(in_pop_cnt), 128'(n_expect));
        if (b2b_armed) begin
          chk(cyc == last_push + 1, "R9 restart gap", 128'(cyc), 128'(last_push + 1));
          b2b_armed = 0;
        end
      end
      if (out_push) begin
        if (q_res.size() == 0) begin
          chk(1'b0, "R4 unexpected push", 128'(1), 128'(0));
        end else begin
          logic [127:0] er;
          int el, en;
          er = q_res.pop_front();
          el = q_lat.pop_front();
          en = q_n.pop_front();
          chk(out_words == er, "R5/R6 result words", out_words, er);
          chk(int'(out_cnt) == en, "R4 push count", 128'(out_cnt), 128'(en));
          chk(run == el, "R3 busy length", 128'(run), 128'(el));
        end
        run = 0;
        last_push = cyc;
        post_push = 1;
      end
    end
  end

  // Reference model
  logic [127:0] iv_m = '0;

  function automatic logic [127:0] fwd(logic [127:0] v, bit w);
    logic [63:0] t;
    if (w) return {v[119:0], v[127:120]} ^ KEY;
    t = v[127:64];
    return {({t[55:0], t[63:56]} ^ KEY[127:64]), 64'd0};
  endfunction

  function automatic logic [127:0] inv(logic [127:0] v, bit w);
    logic [127:0] u;
    logic [63:0] t;
    if (w) begin
      u = v ^ KEY;
      return {u[7:0], u[127:8]};
    end
    t = v[127:64] ^ KEY[127:64];
    return {{t[7:0], t[63:8]}, 64'd0};
  endfunction

  function automatic int lat_of(logic [1:0] a, logic [1:0] k);
    if (a == 2'b00) return 16;
    if (a == 2'b01) return 48;
    if (k == 2'b00) return 14;
    if (k == 2'b01) return 16;
    return 18;
  endfunction

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  // Driver: set config, compute expectation, queue it, feed words
  task automatic send(input logic [1:0] a, input logic [1:0] k, input bit dec, input logic [1:0] ch,
                      input logic [127:0] x, input bit split);
    bit w;
    int n;
    logic [127:0] xs, ivs, y, ivn;
    w = (a == 2'b10);
    n = w ? 4 : 2;
    algo = a; keylen = k; decrypt = dec; chain_mode = ch;
    n_expect = n;
    xs  = w ? x : {x[127:64], 64'd0};
    ivs = w ? iv_m : {iv_m[127:64], 64'd0};
    ivn = ivs;
    if (ch == 2'b01) begin
      if (dec) begin y = inv(xs, w) ^ ivs; ivn = xs; end
      else begin y = fwd(xs ^ ivs, w); ivn = y; end
    end else if (ch == 2'b10) begin
      y = xs ^ fwd(ivs, w);
      ivn = w ? ivs + 128'd1 : {ivs[127:64] + 64'd1, 64'd0};
    end else begin
      y = dec ? inv(xs, w) : fwd(xs, w);
    end
    if (w) iv_m = ivn;
    else iv_m[127:64] = ivn[127:64];
    q_res.push_back(y);
    q_lat.push_back(lat_of(a, k));
    q_n.push_back(n);
    for (int i = 0; i < n; i++) begin
      mem[wr_p % 64] = x[127 - 32*i -: 32];
      wr_p = wr_p + 1;
      if (split && i == 0) begin
        int r0;
        r0 = rd_p;
        repeat (6) step();
        chk(rd_p == r0 && !busy, "R1 short input level", 128'(rd_p), 128'(r0));
      end
    end
  endtask

  task automatic wait_done(input int left);
    int guard = 0;
    while ((q_res.size() > left || busy) && guard < 400) begin
      step();
      guard++;
    end
    step();
  endtask

  task automatic hold_check(input string req);
    int r0;
    r0 = rd_p;
    repeat (8) step();
    chk(rd_p == r0 && !busy, req, 128'(rd_p), 128'(r0));
  endtask

  bit done = 0;

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    rst_n = 0; enable = 0; decrypt = 0; algo = 2'b00; keylen = 2'b00; chain_mode = 2'b00;
    out_free = 5'd8; iv_wr = 0; iv_wdata = '0;
    repeat (3) step();
    // R10 reset state
    chk(!busy && !in_pop && !out_push, "R10 reset strobes", {busy, in_pop, out_push}, 0);
    chk(iv_o == '0, "R10 reset iv", iv_o, '0);
    rst_n = 1;
    step();

    // R1 enable low blocks start
    send(2'b00, 2'b00, 0, 2'b00, 128'h01234567_89ABCDEF_0, 0);
    hold_check("R1 enable low");
    enable = 1;
    wait_done(0);

    // R1 one word short for DES
    send(2'b00, 2'b00, 1, 2'b00, 128'hDEADBEEF_CAFEF00D_0, 1);
    wait_done(0);

    // R1 one location short for AES
    out_free = 5'd3;
    send(2'b10, 2'b00, 0, 2'b00, 128'h00112233_44556677_8899AABB_CCDDEEFF, 0);
    hold_check("R1 output space short");
    out_free = 5'd4;
    wait_done(0);
    out_free = 5'd8;

    // R3 latencies, R5 both directions
    send(2'b10, 2'b01, 1, 2'b00, 128'hA5A5A5A5_5A5A5A5A_F0F0F0F0_0F0F0F0F, 0); wait_done(0);
    send(2'b10, 2'b10, 0, 2'b00, 128'h13579BDF_2468ACE0_FEDCBA98_76543210, 0); wait_done(0);
    send(2'b10, 2'b11, 1, 2'b00, 128'h11111111_22222222_33333333_44444444, 0); wait_done(0);
    send(2'b01, 2'b00, 0, 2'b00, 128'h89ABCDEF_01234567_0, 0); wait_done(0);

    // R8 idle load of chaining value
    iv_wdata = 128'hC0DEC0DE_12345678_9ABCDEF0_0BADF00D;
    iv_wr = 1; step(); iv_wr = 0;
    iv_m = 128'hC0DEC0DE_12345678_9ABCDEF0_0BADF00D;
    chk(iv_o == iv_m, "R8 idle iv load", iv_o, iv_m);

    // R6 CBC chains
    send(2'b10, 2'b00, 0, 2'b01, 128'h0A0B0C0D_01020304_05060708_090A0B0C, 0); wait_done(0);
    send(2'b10, 2'b00, 0, 2'b01, 128'hFFFFFFFF_00000000_12121212_34343434, 0); wait_done(0);
    chk(iv_o == iv_m, "R6 CBC enc iv", iv_o, iv_m);
    send(2'b10, 2'b01, 1, 2'b01, 128'h76767676_54545454_32323232_10101010, 0); wait_done(0);
    chk(iv_o == iv_m, "R6 CBC dec iv", iv_o, iv_m);
    send(2'b00, 2'b00, 0, 2'b01, 128'h11223344_55667788_0, 0); wait_done(0);
    send(2'b01, 2'b00, 1, 2'b01, 128'h99AABBCC_DDEEFF00_0, 0); wait_done(0);
    chk(iv_o == iv_m, "R6 CBC DES half iv", iv_o, iv_m);

    // R6 counter mode
    send(2'b10, 2'b10, 0, 2'b10, 128'h01010101_02020202_03030303_04040404, 0); wait_done(0);
    send(2'b10, 2'b10, 1, 2'b10, 128'h05050505_06060606_07070707_08080808, 0); wait_done(0);
    send(2'b00, 2'b00, 0, 2'b10, 128'h0F0F0F0F_F0F0F0F0_0, 0); wait_done(0);
    chk(iv_o == iv_m, "R6 counter iv", iv_o, iv_m);

    // R8 write while busy ignored
    send(2'b10, 2'b00, 0, 2'b00, 128'h31415926_53589793_23846264_33832795, 0);
    step(); step();
    iv_wdata = 128'hFFFF0000_FFFF0000_FFFF0000_FFFF0000;
    iv_wr = 1; step(); iv_wr = 0;
    wait_done(0);
    chk(iv_o == iv_m, "R8 busy iv write ignored", iv_o, iv_m);

    // R7 config sampled at start, enable clear does not abort
    send(2'b10, 2'b10, 0, 2'b01, 128'h27182818_28459045_23536028_74713526, 0);
    step(); step();
    chk(busy == 1'b1, "R7 block running", 128'(busy), 128'(1));
    enable = 0;
    send(2'b00, 2'b00, 1, 2'b00, 128'h0BADCAFE_FEEDFACE_0, 0);
    wait_done(1);
    hold_check("R7 no start after enable clear");
    chk(q_res.size() == 1, "R7 running block completed", 128'(q_res.size()), 128'(1));
    enable = 1;
    wait_done(0);

    // R9 back-to-back
    send(2'b00, 2'b00, 0, 2'b00, 128'h10203040_50607080_0, 0);
    send(2'b00, 2'b00, 0, 2'b00, 128'h90A0B0C0_D0E0F000_0, 0);
    step(); step();
    b2b_armed = 1;
    wait_done(0);
    chk(b2b_armed == 0, "R9 second block started", 128'(b2b_armed), 128'(0));

    // R1 reserved algorithm never starts
    algo = 2'b11;
    for (int i = 0; i < 4; i++) begin
      mem[wr_p % 64] = 32'h5555AAAA;
      wr_p = wr_p + 1;
    end
    hold_check("R1 reserved algorithm");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule